// File: doc/BRIEF.md
# Stacked Integer Register Window Engine

This block gives a pipeline a stack of integer register frames that is deeper than the physical register file holding them. A call places a new frame directly above the caller's frame, so the caller's registers never need an explicit save. A return releases the current frame and makes the caller's frame current again; the caller's frame size comes back in with the return command, because software keeps the saved frame marker. The physical file works as a ring: the virtual position of a register, taken modulo the file size, selects its physical entry. Floating-point registers are not stacked.

When a call would need more entries than the ring has, the engine holds the pipeline with `stall` and writes the oldest resident registers to a backing store in memory, one 64-bit word per register. When a return uncovers registers that were moved out, it reads them back. No flush occurs; the pipeline is only held. Every register carries one deferred-exception bit that does not fit into a memory word. These bits are gathered in a 64-bit collection register while spilling, and that register is itself written to memory at every slot whose address bits [8:3] are all ones. On a fill the bits are restored from it. The memory request port uses valid/ready. The engine keeps at most one request in flight. A request stays stable while `mem_req_ready` is low. Each accepted request receives exactly one `mem_rsp_valid` pulse: an acknowledge for a write, or the data for a read. The response has no back-pressure.

Top module: `reg_stack_engine`

## Requirements
- R1: After reset `stall` and `mem_req_valid` are low, the current frame is empty and `rd_data` and `rd_nat` read as zero.
- R2: An accepted call of size N places the new frame at base b+s, where b and s are the old base and size. An accepted return of caller size M sets the base to b-M and the size to M. `rd_phys` equals (base + `rd_idx`) modulo PHYS_REGS.
- R3: A write with `wr_idx` below the frame size stores the data and the deferred-exception bit, and reading the same index returns both. A write at an index at or beyond the frame size is ignored. A read at such an index returns zero for both data and bit.
- R4: When base + size would exceed the spilled count + PHYS_REGS, the engine moves the oldest resident registers to memory, lowest virtual position first, until the frame fits.
- R5: Spill words go to consecutive 8-byte slots starting at BS_BASE. A slot whose address bits [8:3] equal 63 receives the collection word instead. In that word, bit i holds the deferred-exception bit of the register stored at the slot whose bits [8:3] equal i.
- R6: When a return leaves the new base below the spilled count, the engine reads words back from the highest slot downward. Collection slots reload the collection register. Each register gets its data word and its deferred-exception bit restored.
- R7: A command that needs a spill or a fill raises `stall` in the cycle after it is accepted. `stall` stays high until the cycle after the final response. A command that fits causes no stall, and the resident registers do not change while `stall` is low.
- R8: Commands presented while `stall` is high are ignored. A call larger than PHYS_REGS is ignored. A return whose size exceeds the current base is ignored.
- R9: A request that is not accepted keeps its valid, write, address and data stable. A response arrives only while one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_is_ret | input | 1 | 1 = return, 0 = call |
| cmd_size | input | $clog2(PHYS_REGS+1) | New frame size (call) or caller frame size (return) |
| stall | output | 1 | Pipeline hold while spilling or filling |
| rd_idx | input | $clog2(PHYS_REGS+1) | Read index within the current frame |
| rd_phys | output | $clog2(PHYS_REGS) | Physical entry mapped to `rd_idx` |
| rd_data | output | DATA_W | Read data |
| rd_nat | output | 1 | Read deferred-exception bit |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | $clog2(PHYS_REGS+1) | Write index within the current frame |
| wr_data | input | DATA_W | Write data |
| wr_nat | input | 1 | Write deferred-exception bit |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request ready |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | ADDR_W | Byte address of the slot |
| mem_req_wdata | output | DATA_W | Store data |
| mem_rsp_valid | input | 1 | Response pulse |
| mem_rsp_rdata | input | DATA_W | Load data |

## Verification
The bench builds the block with PHYS_REGS = 8, BS_BASE = 0 and 64-bit words. A small ring makes overflow happen after only two frames of six registers. Fourteen nested calls then spill 76 registers, which takes the spill across the first collection slot at address 0x1F8. The full unwind fills back through that slot. This shows that the collection word is both written and read, and that data and deferred-exception bits survive the round trip. The memory model lowers `mem_req_ready` every third cycle, so requests are held under back-pressure.

// File: rtl/regstk_pkg.sv
package regstk_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_EVAL, ENG_REQ, ENG_WAIT} eng_state_e;
  typedef enum logic [1:0] {MOP_SPILL_REG, MOP_SPILL_COLL, MOP_FILL_REG, MOP_FILL_COLL} mem_op_e;
  localparam int unsigned SLOT_LSB  = 3;
  localparam int unsigned SLOT_BITS = 6;
  localparam int unsigned COLL_W    = 64;
  localparam logic [SLOT_BITS-1:0] COLL_SLOT = '1;
endpackage

// File: rtl/regstk_file.sv
module regstk_file #(
  parameter int unsigned PHYS_REGS = 16,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned PIDX_W    = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pw_en,
  input  logic [PIDX_W-1:0] pw_idx,
  input  logic [DATA_W-1:0] pw_data,
  input  logic              pw_nat,
  input  logic              fw_en,
  input  logic [PIDX_W-1:0] fw_idx,
  input  logic [DATA_W-1:0] fw_data,
  input  logic              fw_nat,
  input  logic [PIDX_W-1:0] pr_idx,
  output logic [DATA_W-1:0] pr_data,
  output logic              pr_nat,
  input  logic [PIDX_W-1:0] sr_idx,
  output logic [DATA_W-1:0] sr_data,
  output logic              sr_nat
);
  logic [DATA_W-1:0] data_q [PHYS_REGS];
  logic [PHYS_REGS-1:0] nat_q;

  for (genvar g = 0; g < PHYS_REGS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[g] <= '0;
        nat_q[g]  <= 1'b0;
      end else if (fw_en && fw_idx == PIDX_W'(g)) begin
        data_q[g] <= fw_data;
        nat_q[g]  <= fw_nat;
      end else if (pw_en && pw_idx == PIDX_W'(g)) begin
        data_q[g] <= pw_data;
        nat_q[g]  <= pw_nat;
      end
    end
  end

  assign pr_data = data_q[pr_idx];
  assign pr_nat  = nat_q[pr_idx];
  assign sr_data = data_q[sr_idx];
  assign sr_nat  = nat_q[sr_idx];
endmodule

// File: rtl/regstk_frame_ctrl.sv
module regstk_frame_ctrl #(
  parameter int unsigned PHYS_REGS = 16,
  parameter int unsigned VPOS_W    = 16,
  parameter int unsigned SZ_W      = $clog2(PHYS_REGS+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_is_ret,
  input  logic [SZ_W-1:0]   cmd_size,
  input  logic              busy,
  input  logic              spill_step,
  input  logic              fill_step,
  output logic [VPOS_W-1:0] bof,
  output logic [SZ_W-1:0]   sof,
  output logic [VPOS_W-1:0] spill_lo,
  output logic              need_spill,
  output logic              need_fill,
  output logic              start
);
  localparam int unsigned EXT_W = VPOS_W + 1;

  logic [VPOS_W-1:0] bof_q, spill_lo_q, nxt_bof;
  logic [SZ_W-1:0]   sof_q, nxt_sof;
  logic [VPOS_W-1:0] size_v;
  logic              call_ok, ret_ok;

  function automatic logic overflows(input logic [VPOS_W-1:0] b, input logic [SZ_W-1:0] s,
                                     input logic [VPOS_W-1:0] lo);
    return (EXT_W'(b) + EXT_W'(s)) > (EXT_W'(lo) + EXT_W'(PHYS_REGS));
  endfunction

  assign size_v  = VPOS_W'(cmd_size);
  assign call_ok = cmd_valid && !busy && !cmd_is_ret && (cmd_size <= SZ_W'(PHYS_REGS));
  assign ret_ok  = cmd_valid && !busy && cmd_is_ret && (size_v <= bof_q);

  always_comb begin
    nxt_bof = bof_q;
    nxt_sof = sof_q;
    if (call_ok) begin
      nxt_bof = bof_q + VPOS_W'(sof_q);
      nxt_sof = cmd_size;
    end else if (ret_ok) begin
      nxt_bof = bof_q - size_v;
      nxt_sof = cmd_size;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bof_q      <= '0;
      sof_q      <= '0;
      spill_lo_q <= '0;
    end else begin
      bof_q <= nxt_bof;
      sof_q <= nxt_sof;
      if (spill_step)     spill_lo_q <= spill_lo_q + VPOS_W'(1);
      else if (fill_step) spill_lo_q <= spill_lo_q - VPOS_W'(1);
    end
  end

  assign need_spill = overflows(bof_q, sof_q, spill_lo_q);
  assign need_fill  = spill_lo_q > bof_q;
  assign start      = (call_ok || ret_ok) &&
                      (overflows(nxt_bof, nxt_sof, spill_lo_q) || (spill_lo_q > nxt_bof));
  assign bof        = bof_q;
  assign sof        = sof_q;
  assign spill_lo   = spill_lo_q;

  // R4: whenever the pipeline runs, the current frame is resident and fits
  p_resident_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!need_spill && !need_fill));
  // R8: a command while held leaves the frame untouched
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(bof_q) && $stable(sof_q)));
  // R7: the resident set only moves while the pipeline is held
  p_no_stall_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(spill_lo_q));
endmodule

// File: rtl/regstk_spill_engine.sv
module regstk_spill_engine
  import regstk_pkg::*;
#(
  parameter int unsigned PHYS_REGS = 16,
  parameter int unsigned VPOS_W    = 16,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BS_BASE = '0,
  parameter int unsigned PIDX_W    = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              need_spill,
  input  logic              need_fill,
  input  logic [VPOS_W-1:0] spill_lo,
  output logic [PIDX_W-1:0] sr_idx,
  input  logic [DATA_W-1:0] sr_data,
  input  logic              sr_nat,
  output logic              fw_en,
  output logic [PIDX_W-1:0] fw_idx,
  output logic [DATA_W-1:0] fw_data,
  output logic              fw_nat,
  output logic              spill_step,
  output logic              fill_step,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(8);

  eng_state_e        state_q;
  mem_op_e           op_q;
  logic [ADDR_W-1:0] addr_q, bs_ptr_q, prev_ptr;
  logic [DATA_W-1:0] wdata_q;
  logic              op_nat_q;
  logic [COLL_W-1:0] coll_q;
  logic              rsp_take;

  function automatic logic [SLOT_BITS-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[SLOT_LSB +: SLOT_BITS];
  endfunction

  assign prev_ptr = bs_ptr_q - WORD_BYTES;
  assign rsp_take = (state_q == ENG_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      op_q     <= MOP_SPILL_REG;
      addr_q   <= '0;
      wdata_q  <= '0;
      op_nat_q <= 1'b0;
      bs_ptr_q <= BS_BASE;
      coll_q   <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: if (start) state_q <= ENG_EVAL;
        ENG_EVAL: begin
          if (need_spill) begin
            state_q <= ENG_REQ;
            addr_q  <= bs_ptr_q;
            if (slot_of(bs_ptr_q) == COLL_SLOT) begin
              op_q    <= MOP_SPILL_COLL;
              wdata_q <= DATA_W'(coll_q);
            end else begin
              op_q     <= MOP_SPILL_REG;
              wdata_q  <= sr_data;
              op_nat_q <= sr_nat;
            end
          end else if (need_fill) begin
            state_q <= ENG_REQ;
            addr_q  <= prev_ptr;
            wdata_q <= '0;
            op_q    <= (slot_of(prev_ptr) == COLL_SLOT) ? MOP_FILL_COLL : MOP_FILL_REG;
          end else begin
            state_q <= ENG_IDLE;
          end
        end
        ENG_REQ: if (mem_req_ready) state_q <= ENG_WAIT;
        ENG_WAIT: if (mem_rsp_valid) begin
          state_q <= ENG_EVAL;
          unique case (op_q)
            MOP_SPILL_REG: begin
              coll_q[slot_of(addr_q)] <= op_nat_q;
              bs_ptr_q <= addr_q + WORD_BYTES;
            end
            MOP_SPILL_COLL: bs_ptr_q <= addr_q + WORD_BYTES;
            MOP_FILL_COLL: begin
              coll_q   <= mem_rsp_rdata[COLL_W-1:0];
              bs_ptr_q <= addr_q;
            end
            MOP_FILL_REG: bs_ptr_q <= addr_q;
            default: ;
          endcase
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign sr_idx        = spill_lo[PIDX_W-1:0];
  assign spill_step    = rsp_take && (op_q == MOP_SPILL_REG);
  assign fill_step     = rsp_take && (op_q == MOP_FILL_REG);
  assign fw_en         = fill_step;
  assign fw_idx        = PIDX_W'(spill_lo - VPOS_W'(1));
  assign fw_data       = mem_rsp_rdata;
  assign fw_nat        = coll_q[slot_of(addr_q)];
  assign busy          = (state_q != ENG_IDLE);
  assign mem_req_valid = (state_q == ENG_REQ);
  assign mem_req_write = (op_q == MOP_SPILL_REG) || (op_q == MOP_SPILL_COLL);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  // R9: an unaccepted request holds still
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
  // R9: responses only for an outstanding request
  p_rsp_expected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (state_q == ENG_WAIT));
endmodule

// File: rtl/reg_stack_engine.sv
module reg_stack_engine #(
  parameter int unsigned PHYS_REGS = 16,
  parameter int unsigned VPOS_W    = 16,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BS_BASE = '0,
  parameter int unsigned SZ_W      = $clog2(PHYS_REGS+1),
  parameter int unsigned PIDX_W    = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_is_ret,
  input  logic [SZ_W-1:0]   cmd_size,
  output logic              stall,
  input  logic [SZ_W-1:0]   rd_idx,
  output logic [PIDX_W-1:0] rd_phys,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_nat,
  input  logic              wr_en,
  input  logic [SZ_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_nat,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  logic [VPOS_W-1:0] bof, spill_lo;
  logic [SZ_W-1:0]   sof;
  logic              need_spill, need_fill, start, busy, spill_step, fill_step;
  logic [PIDX_W-1:0] sr_idx, fw_idx, pw_idx;
  logic [DATA_W-1:0] sr_data, fw_data, pr_data;
  logic              sr_nat, fw_nat, fw_en, pr_nat, pw_en, rd_in_frame;

  regstk_frame_ctrl #(.PHYS_REGS(PHYS_REGS), .VPOS_W(VPOS_W), .SZ_W(SZ_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_ret(cmd_is_ret),
    .cmd_size(cmd_size), .busy(busy), .spill_step(spill_step), .fill_step(fill_step),
    .bof(bof), .sof(sof), .spill_lo(spill_lo), .need_spill(need_spill),
    .need_fill(need_fill), .start(start));

  regstk_spill_engine #(.PHYS_REGS(PHYS_REGS), .VPOS_W(VPOS_W), .DATA_W(DATA_W),
                        .ADDR_W(ADDR_W), .BS_BASE(BS_BASE), .PIDX_W(PIDX_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .need_spill(need_spill), .need_fill(need_fill),
    .spill_lo(spill_lo), .sr_idx(sr_idx), .sr_data(sr_data), .sr_nat(sr_nat),
    .fw_en(fw_en), .fw_idx(fw_idx), .fw_data(fw_data), .fw_nat(fw_nat),
    .spill_step(spill_step), .fill_step(fill_step), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata));

  assign pw_en       = wr_en && !busy && (wr_idx < sof);
  assign pw_idx      = PIDX_W'(bof + VPOS_W'(wr_idx));
  assign rd_phys     = PIDX_W'(bof + VPOS_W'(rd_idx));
  assign rd_in_frame = rd_idx < sof;

  regstk_file #(.PHYS_REGS(PHYS_REGS), .DATA_W(DATA_W), .PIDX_W(PIDX_W)) u_file (
    .clk(clk), .rst_n(rst_n),
    .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(wr_data), .pw_nat(wr_nat),
    .fw_en(fw_en), .fw_idx(fw_idx), .fw_data(fw_data), .fw_nat(fw_nat),
    .pr_idx(rd_phys), .pr_data(pr_data), .pr_nat(pr_nat),
    .sr_idx(sr_idx), .sr_data(sr_data), .sr_nat(sr_nat));

  assign rd_data = rd_in_frame ? pr_data : '0;
  assign rd_nat  = rd_in_frame && pr_nat;
  assign stall   = busy;
endmodule

// File: tb/test_reg_stack_engine.sv
module test_reg_stack_engine;
  localparam int P  = 8;
  localparam int SW = $clog2(P+1);
  localparam int PW = $clog2(P);
  localparam int DW = 64;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_valid, cmd_is_ret, stall, rd_nat, wr_en, wr_nat;
  logic [SW-1:0] cmd_size, rd_idx, wr_idx;
  logic [PW-1:0] rd_phys;
  logic [DW-1:0] rd_data, wr_data, mem_req_wdata, mem_rsp_rdata;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;

  reg_stack_engine #(.PHYS_REGS(P), .VPOS_W(16), .DATA_W(DW), .ADDR_W(AW), .BS_BASE('0))
  i_reg_stack_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_ret(cmd_is_ret),
    .cmd_size(cmd_size), .stall(stall), .rd_idx(rd_idx), .rd_phys(rd_phys),
    .rd_data(rd_data), .rd_nat(rd_nat), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_nat(wr_nat), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata));

  // Backing-store model with periodic back-pressure
  logic [DW-1:0] mem [512];
  int cyc = 0;
  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    mem_req_ready = 1'b0;
  end
  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 0;
  end
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) mem[mem_req_addr[11:3]] <= mem_req_wdata;
      else mem_rsp_rdata <= mem[mem_req_addr[11:3]];
      mem_rsp_valid <= 1'b1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] val(input int p);
    return {32'hBEEF0000 | 32'(p), 32'h5A5A0000 ^ (32'(p) * 32'd977)};
  endfunction
  function automatic logic natof(input int p);
    return (p % 3) == 1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_is_ret = 1'b0; cmd_size = '0;
    rd_idx = '0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; wr_nat = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_cmd(input bit is_ret, input int size);
    cmd_valid = 1'b1; cmd_is_ret = is_ret; cmd_size = SW'(size);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (stall) @(negedge clk);
  endtask

  task automatic wr_reg(input int idx, input logic [63:0] d, input logic n);
    wr_en = 1'b1; wr_idx = SW'(idx); wr_data = d; wr_nat = n;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input logic [63:0] d, input logic n, input string req);
    rd_idx = SW'(idx);
    #1;
    chk(rd_data == d, req, rd_data, d);
    chk(rd_nat == n, req, 64'(rd_nat), 64'(n));
  endtask

  task automatic map_chk(input int idx, input int base, input string req);
    rd_idx = SW'(idx);
    #1;
    chk(rd_phys == PW'(base + idx), req, 64'(rd_phys), 64'(PW'(base + idx)));
  endtask

  task automatic t_reset();
    do_reset();
    chk(stall == 1'b0, "R1 stall", 64'(stall), 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 0);
    rd_chk(0, 64'h0, 1'b0, "R1 empty frame read");
  endtask

  task automatic t_frame_rules();
    do_reset();
    send_cmd(0, 3);                     // base 0, size 3
    chk(stall == 1'b0, "R7 no stall on fitting call", 64'(stall), 0);
    wr_reg(2, 64'h1111_2222_3333_4444, 1'b1);
    rd_chk(2, 64'h1111_2222_3333_4444, 1'b1, "R3 in-frame write/read");
    send_cmd(1, 0);                     // base 0, size 0
    send_cmd(0, 2);                     // base 0, size 2
    map_chk(1, 0, "R2 mapping base 0");
    wr_reg(2, 64'hDEAD_DEAD_DEAD_DEAD, 1'b0);   // out of frame: ignored
    rd_chk(2, 64'h0, 1'b0, "R3 out-of-frame read");
    send_cmd(0, 9);                     // larger than file: ignored
    map_chk(1, 0, "R8 oversize call ignored");
    send_cmd(0, 1);                     // base 2, size 1
    map_chk(0, 2, "R2 call stacks on caller");
    rd_chk(0, 64'h1111_2222_3333_4444, 1'b1, "R3 ignored write left entry intact");
    send_cmd(1, 5);                     // 5 > base 2: ignored
    map_chk(0, 2, "R8 oversize return ignored");
    send_cmd(1, 2);                     // back to base 0, size 2
    map_chk(1, 0, "R2 return restores base");
  endtask

  task automatic t_deep_nest();
    do_reset();
    for (int k = 0; k < 14; k++) begin
      send_cmd(0, 6);
      if (k == 0) chk(stall == 1'b0, "R7 first call fits", 64'(stall), 0);
      if (k == 1) begin
        chk(stall == 1'b1, "R7 stall after overflowing call", 64'(stall), 1);
        send_cmd(0, 2);                 // during stall: ignored
      end
      wait_idle();
      map_chk(0, 6 * k, "R2 nested mapping");
      for (int i = 0; i < 6; i++) wr_reg(i, val(6 * k + i), natof(6 * k + i));
    end
    rd_chk(5, val(83), natof(83), "R3 top frame content");
    for (int p = 0; p < 76; p++) begin
      int slot = p + p / 63;
      chk(mem[slot] == val(p), "R4 R5 spilled word", mem[slot], val(p));
    end
    for (int b = 0; b < 63; b++)
      chk(mem[63][b] == natof(b), "R5 collection bit", 64'(mem[63][b]), 64'(natof(b)));
    chk(mem[76] == val(75) && mem[77] == 64'h0, "R4 spill stopped at fit", mem[77], 64'h0);
    for (int k = 13; k >= 1; k--) begin
      send_cmd(1, 6);
      if (k == 13) chk(stall == 1'b1, "R7 stall after underflowing return", 64'(stall), 1);
      wait_idle();
      for (int i = 0; i < 6; i++)
        rd_chk(i, val(6 * (k - 1) + i), natof(6 * (k - 1) + i), "R6 filled register");
    end
    map_chk(0, 0, "R8 stall-time call had no effect");
    chk(mem_req_valid == 1'b0, "R9 quiet after unwind", 64'(mem_req_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frame_rules();
    t_deep_nest();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule